// File: doc/BRIEF.md
# SPI Serial-Clock Prescaler

This block turns the core clock into the half-period toggle strobe that an SPI master's shift engine uses to flip its serial clock. The divisor comes from an 8-bit prescale field, and a static mode input selects one of two ways to read that field. The legacy encoding selects an even divisor between 4 and 30. The extended encoding multiplies a 4-bit mantissa by a power of two, and the 3-bit exponent sits in bits that are not next to each other.

Each period of the serial clock has a high half and then a low half. The strobe `tick_o` is high in the last core cycle of each half, and `phase_o` shows which half is running. When the divisor is odd, the high half is one core cycle longer than the low half. The block takes the divisor at the start of each high half and holds it for the rest of that period. A change to the prescale field or the mode therefore never shortens or stretches a half that has already begun.

Top module: `spi_clk_prescaler`

## Requirements
- R1: In legacy mode (`ext_mode_i`=0), when bit 4 of `prescale_i` is set and N = `prescale_i[3:0]` is 2 or more, the serial-clock period is 2N core cycles, split into two halves of N cycles each.
- R2: In legacy mode, when bit 4 is clear or N is below 2, the divisor is clamped to 4, which gives halves of 2 cycles each.
- R3: In legacy mode, bits 7:5 of `prescale_i` have no effect on the period.
- R4: In extended mode (`ext_mode_i`=1), the mantissa M is `prescale_i[3:0]` and the exponent E is {bit 7, bit 6, bit 4}, with bit 4 as the least significant bit of E. For M of 2 or more, the divisor is M·2^E, which reaches 1920 at M=15 and E=7.
- R5: In extended mode, a mantissa of 0 or 1 is treated as 2, so the divisor is 2·2^E.
- R6: In extended mode, bit 5 of `prescale_i` has no effect on the period.
- R7: For a divisor D, the high half (`phase_o`=1) lasts ceil(D/2) cycles and the low half (`phase_o`=0) lasts floor(D/2) cycles. `tick_o` is high in the last cycle of each half, and `phase_o` toggles on the clock edge that follows a tick.
- R8: A new divisor is taken only at the start of a high half. A half that is already running, and the low half that follows it, keep the lengths that applied when that period began.
- R9: While reset is held, `phase_o` is 0 and `tick_o` is 1. The first high half begins on the first clock edge after reset is released and uses the divisor present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_mode_i | input | 1 | Encoding select: 0 = legacy, 1 = extended |
| prescale_i | input | 8 | Prescale field |
| tick_o | output | 1 | High in the last core cycle of each serial-clock half |
| phase_o | output | 1 | 1 during the high half, 0 during the low half |

## Verification
The bench sweeps all 256 prescale values in legacy mode. This shows the even-divisor decode apart from the clamp, and both apart from the ignored upper bits. In extended mode it sweeps every mantissa and exponent pair with bit 5 clear, which covers the non-contiguous exponent bits, the mantissa floor of 2 and the 1920 maximum. It then repeats the small exponents with bit 5 set to show that bit has no effect. Odd mantissas with exponent 0 separate the longer high half from the low half. A prescale change made in the middle of a high half shows that the new value waits for the next period boundary.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

  typedef enum logic {
    PRESC_LEGACY = 1'b0,
    PRESC_EXT    = 1'b1
  } presc_mode_e;

  // legacy floor, also the clamp value
  localparam int unsigned LEG_MIN_DIV = 4;
  // extended mantissa floor
  localparam int unsigned EXT_MIN_MANT = 2;

endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
  import spi_presc_pkg::*;
#(
  parameter int unsigned MANT_W = 4,
  parameter int unsigned EXP_W  = 3,
  localparam int unsigned PRE_W = MANT_W + EXP_W + 1,
  localparam int unsigned DIV_W = MANT_W + (1 << EXP_W) - 1
) (
  input  logic             ext_mode_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic [DIV_W-1:0] div_o
);

  presc_mode_e        mode;
  logic [MANT_W-1:0]  mant;
  logic [MANT_W-1:0]  mant_eff;
  logic [EXP_W-1:0]   expo;
  logic               leg_on;
  logic [DIV_W-1:0]   leg_div;
  logic [DIV_W-1:0]   ext_div;

  always_comb begin
    mode   = presc_mode_e'(ext_mode_i);
    mant   = prescale_i[MANT_W-1:0];
    // exponent lsb sits right above the mantissa, upper bits at the top
    expo   = {prescale_i[PRE_W-1 -: EXP_W-1], prescale_i[MANT_W]};
    leg_on = prescale_i[MANT_W];

    if (!leg_on || ({1'b0, mant, 1'b0} < (MANT_W+2)'(LEG_MIN_DIV)))
      leg_div = DIV_W'(LEG_MIN_DIV);
    else
      leg_div = DIV_W'({mant, 1'b0});

    mant_eff = (mant < MANT_W'(EXT_MIN_MANT)) ? MANT_W'(EXT_MIN_MANT) : mant;
    ext_div  = DIV_W'(mant_eff) << expo;

    div_o = (mode == PRESC_EXT) ? ext_div : leg_div;
  end

endmodule

// File: rtl/spi_presc_split.sv
module spi_presc_split #(
  parameter int unsigned DIV_W = 11
) (
  input  logic [DIV_W-1:0] div_i,
  output logic [DIV_W-1:0] hi_len_o,
  output logic [DIV_W-1:0] lo_len_o
);

  logic [DIV_W:0] sum;

  always_comb begin
    sum      = {1'b0, div_i} + (DIV_W+1)'(1);
    hi_len_o = sum[DIV_W:1];        // ceil(D/2)
    lo_len_o = div_i >> 1;          // floor(D/2)
  end

endmodule

// File: rtl/spi_presc_timer.sv
module spi_presc_timer #(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] hi_len_i,
  input  logic [DIV_W-1:0] lo_len_i,
  output logic             tick_o,
  output logic             phase_o
);

  logic             phase_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] hi_q;
  logic [DIV_W-1:0] lo_q;
  logic [DIV_W-1:0] cur_len;

  assign cur_len = phase_q ? hi_q : lo_q;
  assign tick_o  = (cnt_q == cur_len - DIV_W'(1));
  assign phase_o = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      hi_q    <= DIV_W'(1);
      lo_q    <= DIV_W'(1);
    end else if (tick_o) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
      // end of low half = period boundary: take new lengths
      if (!phase_q) begin
        hi_q <= hi_len_i;
        lo_q <= lo_len_i;
      end
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler #(
  parameter int unsigned MANT_W = 4,
  parameter int unsigned EXP_W  = 3,
  localparam int unsigned PRE_W = MANT_W + EXP_W + 1,
  localparam int unsigned DIV_W = MANT_W + (1 << EXP_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_mode_i,
  input  logic [PRE_W-1:0] prescale_i,
  output logic             tick_o,
  output logic             phase_o
);

  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] hi_len;
  logic [DIV_W-1:0] lo_len;

  spi_presc_decode #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
  ) u_decode (
    .ext_mode_i (ext_mode_i),
    .prescale_i (prescale_i),
    .div_o      (div)
  );

  spi_presc_split #(
    .DIV_W (DIV_W)
  ) u_split (
    .div_i    (div),
    .hi_len_o (hi_len),
    .lo_len_o (lo_len)
  );

  spi_presc_timer #(
    .DIV_W (DIV_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_len_i (hi_len),
    .lo_len_i (lo_len),
    .tick_o   (tick_o),
    .phase_o  (phase_o)
  );

endmodule

// File: rtl/spi_presc_chk.sv
module spi_presc_chk #(
  parameter int unsigned MANT_W = 4,
  parameter int unsigned EXP_W  = 3,
  localparam int unsigned DIV_W = MANT_W + (1 << EXP_W) - 1,
  localparam int unsigned MAX_HALF = ((((1 << MANT_W) - 1) << ((1 << EXP_W) - 1)) + 1) / 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_o,
  input logic phase_o
);

  logic [DIV_W-1:0] half_cnt_q;
  logic [DIV_W-1:0] hi_seen_q;
  logic             have_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_cnt_q <= '0;
      hi_seen_q  <= '0;
      have_hi_q  <= 1'b0;
    end else begin
      half_cnt_q <= tick_o ? '0 : half_cnt_q + DIV_W'(1);
      if (tick_o && phase_o) begin
        hi_seen_q <= half_cnt_q + DIV_W'(1);
        have_hi_q <= 1'b1;
      end
    end
  end

  p_phase_flip_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (phase_o != $past(phase_o)));

  p_phase_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(phase_o));

  // low half equals high half or is one cycle shorter
  p_half_balance_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !phase_o && have_hi_q) |->
      ((half_cnt_q + DIV_W'(1) <= hi_seen_q) &&
       (hi_seen_q - half_cnt_q - DIV_W'(1) <= DIV_W'(1))));

  p_half_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_cnt_q < DIV_W'(MAX_HALF));

endmodule

bind spi_clk_prescaler spi_presc_chk #(
  .MANT_W (MANT_W),
  .EXP_W  (EXP_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_o  (tick_o),
  .phase_o (phase_o)
);

// File: tb/tb_spi_clk_prescaler.sv
module tb_spi_clk_prescaler;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_mode_i = 1'b0;
  logic [7:0] prescale_i = 8'h00;
  logic       tick_o;
  logic       phase_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk_i = ~clk_i;

  spi_clk_prescaler dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .prescale_i (prescale_i),
    .tick_o     (tick_o),
    .phase_o    (phase_o)
  );

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (mode=%0d prescale=0x%02h)",
               req, act, exp_v, ext_mode_i, prescale_i);
    end
  endtask

  function automatic int exp_div(input logic ext, input logic [7:0] p);
    int m, e, n;
    if (!ext) begin
      n = p & 15;
      return (((p & 16) == 0) || (n < 2)) ? 4 : 2 * n;
    end
    m = p & 15;
    e = ((p >> 6) & 3) * 2 + ((p >> 4) & 1);
    if (m < 2) m = 2;
    return m * (1 << e);
  endfunction

  function automatic string tag_of(input logic ext, input logic [7:0] p);
    if (!ext) begin
      if ((p & 8'hE0) != 0) return "R3";
      if (((p & 16) == 0) || ((p & 15) < 2)) return "R2";
      return "R1";
    end
    if ((p & 8'h20) != 0) return "R6";
    if ((p & 15) < 2) return "R5";
    return "R4";
  endfunction

  task automatic sync_boundary();
    do @(negedge clk_i); while (!(tick_o && !phase_o));
  endtask

  task automatic count_half(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!tick_o);
  endtask

  task automatic run_one(input logic ext, input logic [7:0] p);
    int hi, lo, d;
    string t;
    ext_mode_i = ext;
    prescale_i = p;
    d = exp_div(ext, p);
    t = tag_of(ext, p);
    sync_boundary();
    count_half(hi);
    check(t, hi, (d + 1) / 2);
    check("R7", int'(phase_o), 1);
    count_half(lo);
    check(t, lo, d / 2);
    check("R7", int'(phase_o), 0);
  endtask

  initial begin
    int n;
    // R9: state while reset is held
    prescale_i = 8'h14;  // legacy, D = 8
    repeat (3) @(negedge clk_i);
    check("R9", int'(phase_o), 0);
    check("R9", int'(tick_o), 1);
    rst_ni = 1'b1;
    count_half(n);
    check("R9", n, 4);
    check("R9", int'(phase_o), 1);

    // R1 R2 R3: full legacy sweep
    for (int p = 0; p < 256; p++) run_one(1'b0, 8'(p));

    // R4 R5 R7: extended sweep, bit 5 clear
    for (int p = 0; p < 256; p++)
      if ((p & 8'h20) == 0) run_one(1'b1, 8'(p));

    // R6: bit 5 set, small exponents
    for (int p = 0; p < 256; p++)
      if (((p & 8'h20) != 0) && ((p & 8'hC0) == 0)) run_one(1'b1, 8'(p));

    // R7: odd divisor, explicit
    run_one(1'b1, 8'h0F);
    run_one(1'b1, 8'h03);

    // R8: change mid high half applies only at next boundary
    ext_mode_i = 1'b0;
    prescale_i = 8'h1A;  // D = 20
    sync_boundary();
    sync_boundary();
    repeat (3) @(negedge clk_i);
    prescale_i = 8'h12;  // D = 4
    n = 3;
    while (!tick_o) begin
      @(negedge clk_i);
      n++;
    end
    check("R8", n, 10);
    count_half(n);
    check("R8", n, 10);
    count_half(n);
    check("R8", n, 2);
    count_half(n);
    check("R8", n, 2);

    // R8: mode switch mid period
    ext_mode_i = 1'b1;
    prescale_i = 8'h05;  // ext D = 5
    sync_boundary();
    repeat (1) @(negedge clk_i);
    ext_mode_i = 1'b0;
    prescale_i = 8'h1F;  // legacy D = 30
    n = 1;
    while (!tick_o) begin
      @(negedge clk_i);
      n++;
    end
    check("R8", n, 3);
    count_half(n);
    check("R8", n, 2);
    count_half(n);
    check("R8", n, 15);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule